// File: doc/BRIEF.md
# Six-Decade BCD Up/Down Counter

This block keeps a six-digit decimal count in packed BCD and steps it once for each rising edge of an external count pulse. The pulse arrives asynchronously. It passes through a synchronizer and an edge detector in the system clock domain. A small state machine follows each pulse from its leading edge to its trailing edge. That machine decides whether the pulse counts, and it shapes two flags that are timed to the pulse. The carry/borrow flag marks a full rollover. The zero flag marks that the count has landed on all zeros.

A direction input selects counting up or down. A count-inhibit input holds off a pulse. An asynchronous clear empties every decade at once. A load port writes one decade at a time with a BCD nibble, using a one-hot strobe that names the decade. All decades step in the same clock through a carry-enable chain, so the count is never seen half-updated. The packed value goes out to a display subsystem.

The pulse state machine has three states:
- **ST_IDLE**: the pulse is low.
- **ST_COUNTED**: the pulse is high and has been counted.
- **ST_BLOCKED**: the pulse is high and is being held off by the inhibit.

It has five transitions:
- ST_IDLE to ST_COUNTED, on a rising edge with the inhibit low. This applies one step.
- ST_IDLE to ST_BLOCKED, on a rising edge with the inhibit high.
- ST_BLOCKED to ST_COUNTED, when the inhibit drops while the pulse is still high. This applies one step.
- ST_BLOCKED to ST_IDLE, on a falling edge.
- ST_COUNTED to ST_IDLE, on a falling edge.

Top module: `decade_tally`

## Requirements
- R1: With `up_dn` high, each counted pulse adds one to the count. Each decade goes from 9 to 0 and passes a carry to the next decade up. 999999 goes to 000000. Decade i sits in `value[4i+3:4i]`, and decade 0 is the least significant. The count changes on the third rising clock edge after `cnt_in` rises.
- R2: With `up_dn` low, each counted pulse subtracts one. Each decade goes from 0 to 9 and passes a borrow upward. 000000 goes to 999999.
- R3: If `inhibit` is high at the rising edge of the pulse and stays high until the pulse falls, the pulse leaves the count unchanged.
- R4: If `inhibit` is high at the rising edge but drops while the pulse is still high, the pulse is counted at that point.
- R5: `carry` goes high with the counted edge that takes the count to 000000 when counting up, or to 999999 when counting down. It goes low with the falling edge of the same pulse. It is low for every other pulse.
- R6: `zero` goes high with a counted edge that leaves every decade at zero. It stays high until the falling edge of that pulse.
- R7: While `load_req` is high, every clock in which `load_sel` has exactly one bit set writes `load_nib` into decade i, where i is the index of the set bit. The write is skipped if `load_nib` is above 9 or if more than one bit is set.
- R8: While `load_req` is high, `carry` and `zero` read low, any flag already raised is dropped, and count pulses leave the count unchanged.
- R9: When `clear` is high, every decade reads zero at once. Counting resumes a few clocks after `clear` falls.
- R10: After `rst_n` is released, `value` is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Asynchronous active-high clear of all decades |
| cnt_in | input | 1 | Asynchronous count pulse |
| inhibit | input | 1 | Holds off the current pulse while high |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| load_req | input | 1 | Load in progress; masks the flags and drops count steps |
| load_sel | input | NUM_DIGITS | One-hot decade strobe for loading |
| load_nib | input | 4 | BCD nibble to load |
| value | output | 4*NUM_DIGITS | Packed BCD count |
| carry | output | 1 | Rollover flag, timed to the count pulse |
| zero | output | 1 | All-zero flag, timed to the count pulse |

## Verification
The bench builds the counter with NUM_DIGITS set to 3, which gives a modulus of 1000. That small size lets full sweeps of more than one thousand pulses run in each direction. Every count value is then compared against an integer reference, and every rollover in both directions is reached. The same small size lets the bench drive each load strobe position, the invalid nibbles, the multi-bit strobes, the inhibit cases and a clear from a nonzero count, with short runs between them.

// File: rtl/tally_pkg.sv
package tally_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNTED = 2'd1,
        ST_BLOCKED = 2'd2
    } pulse_state_e;

    localparam logic [3:0] NIB_MAX = 4'd9;
endpackage

// File: rtl/tally_decade.sv
module tally_decade
    import tally_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       step,
    input  logic       up,
    input  logic       ld,
    input  logic [3:0] ld_nib,
    output logic [3:0] digit,
    output logic [3:0] nxt,
    output logic       term
);
    // term: this decade passes a carry (up) or a borrow (down) to the next one
    assign term = up ? (digit == NIB_MAX) : (digit == 4'd0);

    always_comb begin
        nxt = digit;
        if (ld) begin
            nxt = ld_nib;
        end else if (step) begin
            if (up) nxt = term ? 4'd0 : digit + 4'd1;
            else    nxt = term ? NIB_MAX : digit - 4'd1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) digit <= 4'd0;
        else         digit <= nxt;
    end
endmodule

// File: rtl/pulse_edge.sv
module pulse_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            prev <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], din};
            prev <= sr[STAGES-1];
        end
    end

    assign level = sr[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/clr_release.sv
module clr_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rel_n
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) q <= '0;
        else      q <= {q[STAGES-2:0], 1'b1};
    end

    assign rel_n = q[STAGES-1];
endmodule

// File: rtl/decade_tally.sv
module decade_tally
    import tally_pkg::*;
#(
    parameter int NUM_DIGITS  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    cnt_in,
    input  logic                    inhibit,
    input  logic                    up_dn,
    input  logic                    load_req,
    input  logic [NUM_DIGITS-1:0]   load_sel,
    input  logic [3:0]              load_nib,
    output logic [4*NUM_DIGITS-1:0] value,
    output logic                    carry,
    output logic                    zero
);
    localparam int W = 4 * NUM_DIGITS;

    pulse_state_e          state_q, state_d;
    logic                  p_level, p_rise, p_fall;
    logic                  step, step_go;
    logic                  clr_arst, rel_n;
    logic                  sel_onehot, nib_ok;
    logic [NUM_DIGITS-1:0] term, en, ld_vec;
    logic [W-1:0]          nxt_val;
    logic                  wrap, nxt_zero;
    logic                  carry_q, zero_q;

    pulse_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_in),
        .level (p_level),
        .rise  (p_rise),
        .fall  (p_fall)
    );

    assign clr_arst = clear | ~rst_n;

    clr_release #(.STAGES(SYNC_STAGES)) u_rel (
        .clk   (clk),
        .arst  (clr_arst),
        .rel_n (rel_n)
    );

    // Load qualification: exactly one strobe bit set and a valid BCD nibble
    assign sel_onehot = (load_sel != '0) && ((load_sel & (load_sel - 1'b1)) == '0);
    assign nib_ok     = (load_nib <= NIB_MAX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic and the step decision
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (p_rise) begin
                    if (inhibit) begin
                        state_d = ST_BLOCKED;
                    end else begin
                        state_d = ST_COUNTED;
                        step    = 1'b1;
                    end
                end
            end
            ST_COUNTED: begin
                if (p_fall) state_d = ST_IDLE;
            end
            ST_BLOCKED: begin
                if (p_fall) begin
                    state_d = ST_IDLE;
                end else if (!inhibit) begin
                    state_d = ST_COUNTED;
                    step    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign step_go = step & ~load_req;

    // Decade chain with carry-enable look-ahead
    genvar i;
    generate
        for (i = 0; i < NUM_DIGITS; i++) begin : g_dec
            if (i == 0) begin : g_first
                assign en[i] = step_go;
            end else begin : g_rest
                assign en[i] = en[i-1] & term[i-1];
            end
            assign ld_vec[i] = load_req & sel_onehot & nib_ok & load_sel[i];

            tally_decade u_dec (
                .clk    (clk),
                .arst_n (rel_n),
                .step   (en[i]),
                .up     (up_dn),
                .ld     (ld_vec[i]),
                .ld_nib (load_nib),
                .digit  (value[4*i +: 4]),
                .nxt    (nxt_val[4*i +: 4]),
                .term   (term[i])
            );
        end
    endgenerate

    assign wrap     = &term;
    assign nxt_zero = (nxt_val == '0);

    // Flag register, timed to the pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (load_req) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (step_go) begin
            carry_q <= wrap;
            zero_q  <= nxt_zero;
        end else if (p_fall) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end
    end

    assign carry = carry_q & ~load_req;
    assign zero  = zero_q & ~load_req;
endmodule

// File: rtl/decade_tally_chk.sv
module decade_tally_chk #(
    parameter int NUM_DIGITS = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear,
    input logic                    load_req,
    input logic [NUM_DIGITS-1:0]   load_sel,
    input logic [3:0]              load_nib,
    input logic [4*NUM_DIGITS-1:0] value,
    input logic                    carry,
    input logic                    zero,
    input logic                    rel_n
);
    logic [4*NUM_DIGITS-1:0] all_nine;
    always_comb begin
        for (int k = 0; k < NUM_DIGITS; k++) all_nine[4*k +: 4] = 4'd9;
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (value == '0));

    // R5
    carry_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (value == '0 || value == all_nine));

    // R6
    zero_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (value == '0));

    genvar i;
    generate
        for (i = 0; i < NUM_DIGITS; i++) begin : g_chk
            // R1
            bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                value[4*i +: 4] <= 4'd9);

            // R7
            load_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
                (load_req && rel_n && load_sel == (NUM_DIGITS'(1) << i) && load_nib <= 4'd9)
                |=> (value[4*i +: 4] == $past(load_nib)));
        end
    endgenerate
endmodule

bind decade_tally decade_tally_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load_req (load_req),
    .load_sel (load_sel),
    .load_nib (load_nib),
    .value    (value),
    .carry    (carry),
    .zero     (zero),
    .rel_n    (rel_n)
);

// File: tb/decade_tally_test.sv
module decade_tally_test;
    localparam int ND  = 3;
    localparam int W   = 4 * ND;
    localparam int MOD = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          cnt_in = 1'b0;
    logic          inhibit = 1'b0;
    logic          up_dn = 1'b1;
    logic          load_req = 1'b0;
    logic [ND-1:0] load_sel = '0;
    logic [3:0]    load_nib = 4'd0;
    logic [W-1:0]  value;
    logic          carry, zero;

    int tests = 0;
    int fails = 0;
    int ref_v = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    decade_tally #(.NUM_DIGITS(ND), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cnt_in(cnt_in),
        .inhibit(inhibit), .up_dn(up_dn), .load_req(load_req),
        .load_sel(load_sel), .load_nib(load_nib), .value(value),
        .carry(carry), .zero(zero)
    );

    function automatic int to_bcd(input int v);
        int r = 0;
        int x = v;
        for (int k = 0; k < ND; k++) begin
            r = r | ((x % 10) << (4 * k));
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // One pulse; exp_c/exp_z are the flags expected while it is high
    task automatic pulse(input string req, input bit exp_c, input bit exp_z);
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        chk({req, " carry high phase"}, int'(carry), int'(exp_c));
        chk({req, " zero high phase"}, int'(zero), int'(exp_z));
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        chk({req, " carry after fall"}, int'(carry), 0);
        chk({req, " zero after fall"}, int'(zero), 0);
        chk({req, " value"}, int'(value), to_bcd(ref_v));
    endtask

    task automatic count_up(input string req);
        ref_v = (ref_v + 1) % MOD;
        pulse(req, ref_v == 0, ref_v == 0);
    endtask

    task automatic count_dn(input string req);
        ref_v = (ref_v + MOD - 1) % MOD;
        pulse(req, ref_v == MOD - 1, ref_v == 0);
    endtask

    task automatic load_one(input logic [ND-1:0] sel, input logic [3:0] nib);
        load_req = 1'b1;
        load_sel = sel;
        load_nib = nib;
        @(negedge clk);
        load_req = 1'b0;
        load_sel = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 1 expected 0");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10
        chk("R10 value", int'(value), 0);
        chk("R10 carry", int'(carry), 0);
        chk("R10 zero", int'(zero), 0);

        // R1 full upward sweep through rollover, R5/R6 at wrap
        up_dn = 1'b1;
        for (int k = 0; k < MOD + 5; k++) count_up("R1");

        // R2 full downward sweep through underflow, R5/R6 at wrap
        up_dn = 1'b0;
        for (int k = 0; k < MOD + 5; k++) count_dn("R2");

        // R6 zero reached by counting down to 000
        load_one(3'b001, 4'd1);
        load_one(3'b010, 4'd0);
        load_one(3'b100, 4'd0);
        ref_v = 1;
        chk("R7 load 001", int'(value), to_bcd(1));
        count_dn("R6");

        // R3 inhibit held through the pulse
        up_dn = 1'b1;
        inhibit = 1'b1;
        pulse("R3", 1'b0, 1'b0);
        pulse("R3", 1'b0, 1'b0);
        inhibit = 1'b0;

        // R4 inhibit dropped while the pulse is high
        inhibit = 1'b1;
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 before release", int'(value), to_bcd(ref_v));
        inhibit = 1'b0;
        repeat (3) @(negedge clk);
        ref_v = (ref_v + 1) % MOD;
        chk("R4 after release", int'(value), to_bcd(ref_v));
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7 per-decade loading and rejected writes
        load_one(3'b001, 4'd7);
        load_one(3'b010, 4'd4);
        load_one(3'b100, 4'd2);
        ref_v = 247;
        chk("R7 value 247", int'(value), to_bcd(247));
        load_one(3'b001, 4'd12);
        chk("R7 nibble above 9 skipped", int'(value), to_bcd(247));
        load_one(3'b011, 4'd5);
        chk("R7 two strobes skipped", int'(value), to_bcd(247));

        // R8 pulse during load is dropped
        load_req = 1'b1;
        pulse("R8 pulse during load", 1'b0, 1'b0);
        load_req = 1'b0;
        @(negedge clk);

        // R8 flags masked and dropped by a load
        load_one(3'b001, 4'd9);
        load_one(3'b010, 4'd9);
        load_one(3'b100, 4'd9);
        ref_v = 0;
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 carry at rollover", int'(carry), 1);
        chk("R6 zero at rollover", int'(zero), 1);
        load_req = 1'b1;
        #1;
        chk("R8 carry masked", int'(carry), 0);
        chk("R8 zero masked", int'(zero), 0);
        @(negedge clk);
        load_req = 1'b0;
        @(negedge clk);
        chk("R8 carry dropped", int'(carry), 0);
        chk("R8 zero dropped", int'(zero), 0);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 value", int'(value), 0);

        // R9 asynchronous clear from a nonzero count
        for (int k = 0; k < 37; k++) count_up("R1");
        #3;
        clear = 1'b1;
        #1;
        chk("R9 immediate zero", int'(value), 0);
        @(negedge clk);
        clear = 1'b0;
        ref_v = 0;
        repeat (4) @(negedge clk);
        chk("R9 held zero", int'(value), 0);
        count_up("R9 resume");
        count_up("R9 resume");

        done = 1'b1;
        summary();
    end
endmodule